// File: doc/BRIEF.md
# Virtualization Mode Control Unit

This unit holds a processor core's hardware virtualization state and executes the commands that change it. The core runs at one of three levels. In normal operation the extension is off. In root operation the monitor runs. In non-root operation a guest runs. Five commands move the core between these levels: turn on, turn off, start a guest, return to the monitor, and continue a guest. Each switch between monitor and guest is one command. The unit checks every command against the current state and refuses illegal ones with a one-cycle fault pulse.

The unit keeps two context-record pointers. One points to the monitor's record. The other points to the record that is currently running. A small associative table remembers which guest records have been started since the extension was last turned on, so that a guest can only be continued after it was started. Each guest switch sends two requests over a valid/ready context-memory port. The first saves the outgoing record and the second restores the incoming one. The mode changes when the restore is acknowledged, and the unit reports busy until then.

Top module: `virt_mode_ctrl`

## Requirements
- R1: After reset, ext_on, root_mode, busy, fault and ctx_req_valid are 0, and mon_ptr and act_ptr are 0.
- R2: cmd_op encodes 1 = turn on, 2 = turn off, 3 = start guest, 4 = return to monitor, 5 = continue guest. A command with any other code (0, 6, 7) is illegal.
- R3: Turn on is legal only while ext_on is 0 and cmd_ptr is non-zero. One cycle after it is taken, ext_on = 1, root_mode = 1 and mon_ptr = act_ptr = cmd_ptr, and no context request is made.
- R4: Turn off is legal only with ext_on = 1 and root_mode = 1. One cycle after it is taken, ext_on, root_mode, mon_ptr and act_ptr are all 0, and the table of started guests is empty.
- R5: Start guest is legal only in root operation with a non-zero cmd_ptr that is either already in the table or finds a free slot. It saves mon_ptr, then restores cmd_ptr, then sets root_mode = 0 and act_ptr = cmd_ptr.
- R6: Continue guest is legal only in root operation with a non-zero cmd_ptr that a start-guest command has placed in the table. Its transfers and final state are the same as for start guest.
- R7: Return to monitor is legal only in non-root operation. It saves act_ptr, then restores mon_ptr, then sets root_mode = 1 and act_ptr = mon_ptr.
- R8: Each switch raises ctx_req_valid first with ctx_req_save = 1 (save) and then with ctx_req_save = 0 (restore). A request keeps ctx_req_addr and ctx_req_save stable until ctx_req_ready is seen, and it completes on a cycle where both valid and ready are high.
- R9: A command is taken on a clock edge where cmd_valid = 1 and busy = 0. Busy is high from the cycle after a switch is taken until the restore completes. root_mode and act_ptr change on that completing edge and on no earlier edge. A command presented only while busy is not taken.
- R10: An illegal command that is taken raises fault for exactly the cycle after it is taken and changes neither state nor context requests.
- R11: The table holds GUEST_SLOTS distinct pointers. Starting a new pointer while the table is full is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code |
| cmd_ptr | input | ADDR_W | Context-record operand |
| busy | output | 1 | Switch in progress; commands are not taken |
| fault | output | 1 | One-cycle pulse for a refused command |
| ext_on | output | 1 | Virtualization extension enabled |
| root_mode | output | 1 | 1 = root (monitor), 0 = non-root (guest) |
| mon_ptr | output | ADDR_W | Monitor context-record pointer |
| act_ptr | output | ADDR_W | Running context-record pointer |
| ctx_req_valid | output | 1 | Context-memory request valid |
| ctx_req_save | output | 1 | 1 = save request, 0 = restore request |
| ctx_req_addr | output | ADDR_W | Record address of the request |
| ctx_req_ready | input | 1 | Context memory accepts the request |

## Verification
The bench builds the unit with ADDR_W = 12 and GUEST_SLOTS = 2. With only two slots, the full-table refusal and the re-start of a pointer that is already recorded both come up after a few guest starts. A scoreboard queue holds the expected save and restore addresses. The context-memory ready line runs either always high or stalling three cycles out of four, which exercises the hold rule and keeps busy high long enough to present a command during a switch.

// File: rtl/vmc_pkg.sv
// Shared encodings for the virtualization mode control unit.
// Assumes a 3-bit command field; codes not listed here are illegal.
package vmc_pkg;
    localparam logic [2:0] OP_TURN_ON  = 3'd1;
    localparam logic [2:0] OP_TURN_OFF = 3'd2;
    localparam logic [2:0] OP_START    = 3'd3;
    localparam logic [2:0] OP_TO_MON   = 3'd4;
    localparam logic [2:0] OP_CONTINUE = 3'd5;

    typedef enum logic [1:0] {
        XF_IDLE    = 2'd0,
        XF_SAVE    = 2'd1,
        XF_RESTORE = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/vmc_guest_table.sv
// Associative table of started guest record pointers.
// Lookup is combinational; an insert of an already present pointer is a no-op.
// Assumes the caller inserts only when the pointer is present or a slot is free.
module vmc_guest_table #(
    parameter int ADDR_W = 16,
    parameter int SLOTS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              ins_en,
    input  logic [ADDR_W-1:0] ins_ptr,
    input  logic [ADDR_W-1:0] look_ptr,
    output logic              look_hit,
    output logic              full
);
    logic [SLOTS-1:0]  valid_q;
    logic [SLOTS-1:0]  look_m;
    logic [SLOTS-1:0]  ins_m;
    logic [SLOTS-1:0]  free_pick;
    logic [ADDR_W-1:0] tag_q [SLOTS];
    logic              ins_hit;

    assign look_hit = |look_m;
    assign ins_hit  = |ins_m;
    assign full     = &valid_q;

    // Pick the lowest-numbered empty slot.
    always_comb begin
        logic found;
        found     = 1'b0;
        free_pick = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!valid_q[i] && !found) begin
                free_pick[i] = 1'b1;
                found        = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign look_m[g] = valid_q[g] && (tag_q[g] == look_ptr);
        assign ins_m[g]  = valid_q[g] && (tag_q[g] == ins_ptr);

        // Hold one recorded pointer; emptied on clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                tag_q[g]   <= '0;
            end else if (clear) begin
                valid_q[g] <= 1'b0;
            end else if (ins_en && !ins_hit && free_pick[g]) begin
                valid_q[g] <= 1'b1;
                tag_q[g]   <= ins_ptr;
            end
        end
    end

    // R11: an insert never arrives when the pointer has no place to go.
    a_r11_slot_avail: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> (ins_hit || !full));
endmodule

// File: rtl/vmc_xfer_seq.sv
// Two-step context transfer sequencer: one save request, then one restore request.
// Each request is held until ready is seen; done pulses on the restore handshake.
module vmc_xfer_seq #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] save_addr,
    input  logic [ADDR_W-1:0] rest_addr,
    input  logic              req_ready,
    output logic              req_valid,
    output logic              req_save,
    output logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              done
);
    import vmc_pkg::*;

    xfer_state_e       state_q;
    logic [ADDR_W-1:0] save_q;
    logic [ADDR_W-1:0] rest_q;

    assign busy      = (state_q != XF_IDLE);
    assign req_valid = busy;
    assign req_save  = (state_q == XF_SAVE);
    assign req_addr  = (state_q == XF_SAVE) ? save_q : rest_q;
    assign done      = (state_q == XF_RESTORE) && req_ready;

    // Step through save then restore, advancing on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XF_IDLE;
            save_q  <= '0;
            rest_q  <= '0;
        end else begin
            case (state_q)
                XF_IDLE: if (start) begin
                    state_q <= XF_SAVE;
                    save_q  <= save_addr;
                    rest_q  <= rest_addr;
                end
                XF_SAVE:    if (req_ready) state_q <= XF_RESTORE;
                XF_RESTORE: if (req_ready) state_q <= XF_IDLE;
                default:    state_q <= XF_IDLE;
            endcase
        end
    end

    // R8: a waiting request keeps its address and kind.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_save)));
    // R8: every transfer episode opens with a save.
    a_r8_save_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> req_save);
endmodule

// File: rtl/virt_mode_ctrl.sv
// Virtualization mode control unit: decodes the five mode commands, checks them
// against the current level, and runs guest switches through the transfer sequencer.
// Assumes the requester holds cmd_valid until it sees busy low.
module virt_mode_ctrl #(
    parameter int ADDR_W      = 16,
    parameter int GUEST_SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_ptr,
    output logic              busy,
    output logic              fault,
    output logic              ext_on,
    output logic              root_mode,
    output logic [ADDR_W-1:0] mon_ptr,
    output logic [ADDR_W-1:0] act_ptr,
    output logic              ctx_req_valid,
    output logic              ctx_req_save,
    output logic [ADDR_W-1:0] ctx_req_addr,
    input  logic              ctx_req_ready
);
    import vmc_pkg::*;

    logic              ext_q, root_q, fault_q;
    logic [ADDR_W-1:0] mon_q, act_q, pend_ptr_q;
    logic              pend_root_q, pend_start_q;
    logic              accept, legal, is_switch, in_root, in_guest, ptr_nz;
    logic              look_hit, tbl_full, xfer_done, seq_busy;
    logic [ADDR_W-1:0] save_addr, rest_addr;

    assign accept   = cmd_valid && !seq_busy;
    assign in_root  = ext_q && root_q;
    assign in_guest = ext_q && !root_q;
    assign ptr_nz   = |cmd_ptr;

    // Decide whether the presented command is allowed in the current level.
    always_comb begin
        legal     = 1'b0;
        is_switch = 1'b0;
        case (cmd_op)
            OP_TURN_ON:  legal = !ext_q && ptr_nz;
            OP_TURN_OFF: legal = in_root;
            OP_START: begin
                legal     = in_root && ptr_nz && (look_hit || !tbl_full);
                is_switch = 1'b1;
            end
            OP_CONTINUE: begin
                legal     = in_root && ptr_nz && look_hit;
                is_switch = 1'b1;
            end
            OP_TO_MON: begin
                legal     = in_guest;
                is_switch = 1'b1;
            end
            default: legal = 1'b0;
        endcase
    end

    assign save_addr = (cmd_op == OP_TO_MON) ? act_q : mon_q;
    assign rest_addr = (cmd_op == OP_TO_MON) ? mon_q : cmd_ptr;

    // Update the level registers on taken commands and on restore completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q        <= 1'b0;
            root_q       <= 1'b0;
            mon_q        <= '0;
            act_q        <= '0;
            fault_q      <= 1'b0;
            pend_ptr_q   <= '0;
            pend_root_q  <= 1'b0;
            pend_start_q <= 1'b0;
        end else begin
            fault_q <= accept && !legal;
            if (accept && legal) begin
                case (cmd_op)
                    OP_TURN_ON: begin
                        ext_q  <= 1'b1;
                        root_q <= 1'b1;
                        mon_q  <= cmd_ptr;
                        act_q  <= cmd_ptr;
                    end
                    OP_TURN_OFF: begin
                        ext_q  <= 1'b0;
                        root_q <= 1'b0;
                        mon_q  <= '0;
                        act_q  <= '0;
                    end
                    default: begin
                        pend_ptr_q   <= rest_addr;
                        pend_root_q  <= (cmd_op == OP_TO_MON);
                        pend_start_q <= (cmd_op == OP_START);
                    end
                endcase
            end
            if (xfer_done) begin
                root_q <= pend_root_q;
                act_q  <= pend_ptr_q;
            end
        end
    end

    vmc_guest_table #(.ADDR_W(ADDR_W), .SLOTS(GUEST_SLOTS)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept && legal && (cmd_op == OP_TURN_OFF)),
        .ins_en   (xfer_done && pend_start_q),
        .ins_ptr  (pend_ptr_q),
        .look_ptr (cmd_ptr),
        .look_hit (look_hit),
        .full     (tbl_full)
    );

    vmc_xfer_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept && legal && is_switch),
        .save_addr (save_addr),
        .rest_addr (rest_addr),
        .req_ready (ctx_req_ready),
        .req_valid (ctx_req_valid),
        .req_save  (ctx_req_save),
        .req_addr  (ctx_req_addr),
        .busy      (seq_busy),
        .done      (xfer_done)
    );

    assign busy      = seq_busy;
    assign fault     = fault_q;
    assign ext_on    = ext_q;
    assign root_mode = root_q;
    assign mon_ptr   = mon_q;
    assign act_ptr   = act_q;

    // R10: a refusal leaves the level registers as they were.
    a_r10_fault_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($stable(ext_on) && $stable(root_mode) && $stable(act_ptr) && $stable(mon_ptr)));
    // R9: with the extension staying on, the mode flips only at the end of a busy switch.
    a_r9_mode_after_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_on && $past(ext_on) && (root_mode != $past(root_mode))) |-> $past(busy));
    // R3: while enabled, both record pointers are non-zero.
    a_r3_ptrs_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        ext_on |-> ((act_ptr != '0) && (mon_ptr != '0)));
    // R4: normal operation shows root clear and no running record.
    a_r4_normal_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_on |-> (!root_mode && (act_ptr == '0)));
endmodule

// File: tb/virt_mode_ctrl_tb_top.sv
// Scoreboard bench: the command task predicts context requests into a queue,
// a monitor pops them on each completed handshake.
module virt_mode_ctrl_tb_top;
    localparam int AW = 12;
    localparam int NS = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_ptr = '0;
    logic          busy, fault, ext_on, root_mode;
    logic [AW-1:0] mon_ptr, act_ptr, ctx_req_addr;
    logic          ctx_req_valid, ctx_req_save;
    logic          ctx_req_ready = 1'b1;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit stall_mode = 1'b0;
    bit done_flag = 1'b0;

    logic [AW:0]   exp_q[$];
    logic          m_ext = 1'b0, m_root = 1'b0;
    logic [AW-1:0] m_mon = '0, m_act = '0;
    logic [AW-1:0] m_list[$];

    always #5 clk = ~clk;

    virt_mode_ctrl #(.ADDR_W(AW), .GUEST_SLOTS(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ptr(cmd_ptr),
        .busy(busy), .fault(fault), .ext_on(ext_on), .root_mode(root_mode),
        .mon_ptr(mon_ptr), .act_ptr(act_ptr), .ctx_req_valid(ctx_req_valid),
        .ctx_req_save(ctx_req_save), .ctx_req_addr(ctx_req_addr), .ctx_req_ready(ctx_req_ready)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Ready pattern changes just after each rising edge.
    always @(posedge clk) begin
        cyc++;
        #1;
        ctx_req_ready <= stall_mode ? (cyc % 4 == 3) : 1'b1;
    end

    // Monitor: at each falling edge, compare completed handshakes and hold behaviour.
    logic          prev_wait = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic          prev_save = 1'b0;
    always @(negedge clk) begin
        if (rst_n && ctx_req_valid) begin
            if (prev_wait)
                chk(ctx_req_addr == prev_addr && ctx_req_save == prev_save,
                    "R8 request held while waiting", int'(ctx_req_addr), int'(prev_addr));
            if (ctx_req_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected request", int'({ctx_req_save, ctx_req_addr}), 0);
                end else begin
                    logic [AW:0] e;
                    e = exp_q.pop_front();
                    chk({ctx_req_save, ctx_req_addr} == e, "R8 request kind/address",
                        int'({ctx_req_save, ctx_req_addr}), int'(e));
                end
            end
        end
        prev_wait = rst_n && ctx_req_valid && !ctx_req_ready;
        prev_addr = ctx_req_addr;
        prev_save = ctx_req_save;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        if (cyc > 100000 && !done_flag) begin
            done_flag = 1'b1;
            chk(1'b0, "watchdog expired", cyc, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic bit in_list(input logic [AW-1:0] p);
        foreach (m_list[i]) if (m_list[i] == p) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk_state(input string tag);
        chk(ext_on == m_ext, {tag, " ext_on"}, int'(ext_on), int'(m_ext));
        chk(root_mode == m_root, {tag, " root_mode"}, int'(root_mode), int'(m_root));
        chk(mon_ptr == m_mon, {tag, " mon_ptr"}, int'(mon_ptr), int'(m_mon));
        chk(act_ptr == m_act, {tag, " act_ptr"}, int'(act_ptr), int'(m_act));
    endtask

    // Predict legality per R2-R7/R11, drive one command, then check the outcome.
    task automatic do_cmd(input logic [2:0] op, input logic [AW-1:0] ptr, input string tag);
        bit lg, sw;
        logic old_root;
        lg = 1'b0; sw = 1'b0;
        case (op)
            3'd1: lg = !m_ext && ptr != 0;
            3'd2: lg = m_ext && m_root;
            3'd3: begin lg = m_ext && m_root && ptr != 0 && (in_list(ptr) || m_list.size() < NS); sw = 1'b1; end
            3'd5: begin lg = m_ext && m_root && ptr != 0 && in_list(ptr); sw = 1'b1; end
            3'd4: begin lg = m_ext && !m_root; sw = 1'b1; end
            default: lg = 1'b0;
        endcase
        if (lg && sw) begin
            if (op == 3'd4) begin
                exp_q.push_back({1'b1, m_act});
                exp_q.push_back({1'b0, m_mon});
            end else begin
                exp_q.push_back({1'b1, m_mon});
                exp_q.push_back({1'b0, ptr});
            end
        end
        old_root = m_root;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_ptr = ptr;
        while (busy) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(fault == !lg, {tag, " R10 fault after take"}, int'(fault), int'(!lg));
        if (lg && sw) begin
            chk(busy == 1'b1, {tag, " R9 busy during switch"}, int'(busy), 1);
            chk(root_mode == old_root, {tag, " R9 mode held until restore"}, int'(root_mode), int'(old_root));
            while (busy) @(negedge clk);
        end
        if (lg) begin
            case (op)
                3'd1: begin m_ext = 1'b1; m_root = 1'b1; m_mon = ptr; m_act = ptr; end
                3'd2: begin m_ext = 1'b0; m_root = 1'b0; m_mon = '0; m_act = '0; m_list.delete(); end
                3'd3: begin m_root = 1'b0; m_act = ptr; if (!in_list(ptr)) m_list.push_back(ptr); end
                3'd5: begin m_root = 1'b0; m_act = ptr; end
                3'd4: begin m_root = 1'b1; m_act = m_mon; end
                default: ;
            endcase
        end
        chk_state(tag);
        @(negedge clk);
        chk(fault == 1'b0, {tag, " R10 fault one cycle only"}, int'(fault), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !fault && !ctx_req_valid, "R1 reset outputs idle",
            int'({busy, fault, ctx_req_valid}), 0);
        chk_state("R1 reset");

        do_cmd(3'd1, 12'h000, "R3 turn on zero ptr");
        do_cmd(3'd4, 12'h000, "R7 return in normal");
        do_cmd(3'd6, 12'h100, "R2 code 6");
        do_cmd(3'd0, 12'h100, "R2 code 0");
        do_cmd(3'd1, 12'h100, "R3 turn on");
        chk(exp_q.size() == 0, "R3 no context traffic", exp_q.size(), 0);
        do_cmd(3'd1, 12'h180, "R3 turn on twice");
        do_cmd(3'd5, 12'h200, "R6 continue unknown");
        do_cmd(3'd4, 12'h000, "R7 return in root");
        do_cmd(3'd3, 12'h000, "R5 start zero ptr");
        do_cmd(3'd3, 12'h200, "R5 start first guest");
        do_cmd(3'd3, 12'h300, "R5 start from guest");
        do_cmd(3'd2, 12'h000, "R4 turn off from guest");
        do_cmd(3'd4, 12'h000, "R7 return to monitor");
        stall_mode = 1'b1;
        do_cmd(3'd3, 12'h300, "R5 start second guest stalled");
        do_cmd(3'd4, 12'h000, "R7 return stalled");
        do_cmd(3'd3, 12'h400, "R11 start with table full");
        do_cmd(3'd3, 12'h200, "R5 restart recorded guest");
        do_cmd(3'd4, 12'h000, "R7 return again");
        do_cmd(3'd5, 12'h300, "R6 continue recorded guest");
        do_cmd(3'd4, 12'h000, "R7 return after continue");

        // R9: a command shown only while busy is not taken.
        begin
            bit saw_fault;
            exp_q.push_back({1'b1, m_mon});
            exp_q.push_back({1'b0, 12'h200});
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 3'd5; cmd_ptr = 12'h200;
            while (busy) @(negedge clk);
            @(negedge clk);
            cmd_op = 3'd7; cmd_ptr = 12'h000;
            @(negedge clk);
            cmd_valid = 1'b0;
            saw_fault = fault;
            while (busy) begin
                @(negedge clk);
                saw_fault = saw_fault | fault;
            end
            @(negedge clk);
            saw_fault = saw_fault | fault;
            chk(!saw_fault, "R9 command during busy not taken", int'(saw_fault), 0);
            m_root = 1'b0; m_act = 12'h200;
            chk_state("R9 after ignored command");
        end
        stall_mode = 1'b0;
        do_cmd(3'd4, 12'h000, "R7 return before off");
        do_cmd(3'd2, 12'h000, "R4 turn off");
        do_cmd(3'd1, 12'h100, "R3 turn on again");
        do_cmd(3'd5, 12'h200, "R4 table emptied by turn off");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all predicted requests seen", exp_q.size(), 0);
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule